// File: doc/BRIEF.md
# Virtually Indexed, Physically Tagged L1 Data Lookup

This block is the lookup stage of a four-way set-associative L1 data cache. A load presents only the untranslated page-offset bits of its virtual address. The set index and the word position both sit inside those bits, so the tag and data arrays are read in the same cycle as the request. Translation runs in parallel with that read.

One cycle later the translation unit supplies the physical page number, a valid flag and a fault flag. The stored tags of the selected set are then compared against the whole page number. A match returns the addressed 32-bit word. A mismatch raises a miss request that carries the physical line address. A missing or faulting translation cancels the lookup, and a request that is not word aligned is flagged as an error.

The next level returns whole lines through a refill port. A tree pseudo-LRU in each set chooses the way that a refill replaces.

Top module: `vipt_l1_lookup`

## Requirements
- R1: After reset every line is invalid, so an aligned lookup with a valid, non-faulting translation reports a miss.
- R2: A request uses `req_voff_i[11:5]` as the set index and `req_voff_i[4:2]` as the word select. Its result is presented combinationally in the cycle after the request, the same cycle in which the translation inputs must be valid.
- R3: A lookup hits when a valid way of the set holds a tag equal to `xlat_ppn_i`. `rdata_o` then carries word k of that line, which is bits [32k+31:32k] of the refilled line.
- R4: A lookup with no matching way raises `miss_o`, and `miss_line_o` = {`xlat_ppn_i`, set index}.
- R5: When `xlat_valid_i` is low or `xlat_fault_i` is high in the result cycle, an aligned lookup raises none of `hit_o`, `miss_o` or `err_o`.
- R6: A request with `req_voff_i[1:0]` non-zero raises `err_o` in its result cycle and never `hit_o` or `miss_o`, whatever the translation state.
- R7: A refill with `fill_line_i` = {tag, set index} writes the whole 256-bit line, the tag and the valid bit. A request issued in the cycle after the refill already sees the new line.
- R8: Each set has a three-node replacement tree. The root bit picks the way pair {0,1} or {2,3}, and the node under it picks within the pair, with 0 meaning the lower side. Each hit and each refill points the nodes on its path away from the way it used. From reset, four refills to one set fill ways 0, 2, 1 and 3 in that order. If way 0 then hits, the next refill replaces way 2.
- R9: Without a request in the previous cycle, `hit_o`, `miss_o` and `err_o` all stay low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| req_valid_i | input | 1 | Load request present |
| req_voff_i | input | 12 | Page-offset bits of the load's virtual address |
| xlat_valid_i | input | 1 | Translation available in the result cycle |
| xlat_fault_i | input | 1 | Translation faulted |
| xlat_ppn_i | input | 20 | Physical page number |
| fill_valid_i | input | 1 | Refill line present |
| fill_line_i | input | 27 | Refill physical line address {tag, index} |
| fill_data_i | input | 256 | Refill line data |
| hit_o | output | 1 | Lookup hit |
| rdata_o | output | 32 | Hit data word |
| miss_o | output | 1 | Miss request to the next level |
| miss_line_o | output | 27 | Physical line address of the miss |
| err_o | output | 1 | Misaligned request |

## Verification
Every lookup result is due exactly one clock after the request cycle. The bench drives a request on a falling edge and drives the translation inputs on the next falling edge. It samples `hit_o`, `rdata_o`, `miss_o` and `err_o` shortly after that edge, once the stage register has loaded on the rising edge in between. A refill takes effect at the rising edge inside its pulse, so the bench issues the following request no earlier than the next falling edge. The replacement checks use hand-derived way orders from reset, including a hit between refills.

// File: rtl/vipt_pkg.sv
`timescale 1ns/1ps
package vipt_pkg;
  typedef enum logic [2:0] {
    LK_IDLE,
    LK_HIT,
    LK_MISS,
    LK_CANCEL,
    LK_ERR
  } lk_res_e;
endpackage

// File: rtl/vipt_tag_array.sv
`timescale 1ns/1ps
module vipt_tag_array #(
  parameter int SETS  = 128,
  parameter int WAYS  = 4,
  parameter int TAG_W = 20,
  localparam int IDX_W = $clog2(SETS)
) (
  input  logic                       clk_i,
  input  logic                       rst_ni,
  input  logic [IDX_W-1:0]           rd_idx_i,
  input  logic                       wr_en_i,
  input  logic [IDX_W-1:0]           wr_idx_i,
  input  logic [WAYS-1:0]            wr_way_i,
  input  logic [TAG_W-1:0]           wr_tag_i,
  output logic [WAYS-1:0][TAG_W-1:0] rd_tag_o,
  output logic [WAYS-1:0]            rd_vld_o
);
  logic [WAYS-1:0] vld_q [SETS];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int s = 0; s < SETS; s++) vld_q[s] <= '0;
      rd_vld_o <= '0;
    end else begin
      if (wr_en_i) vld_q[wr_idx_i] <= vld_q[wr_idx_i] | wr_way_i;
      rd_vld_o <= vld_q[rd_idx_i];
    end
  end

  for (genvar w = 0; w < WAYS; w++) begin : g_way
    logic [TAG_W-1:0] mem [SETS];
    logic [TAG_W-1:0] tag_q;
    always_ff @(posedge clk_i) begin
      if (wr_en_i && wr_way_i[w]) mem[wr_idx_i] <= wr_tag_i;
      tag_q <= mem[rd_idx_i];
    end
    assign rd_tag_o[w] = tag_q;
  end

  assert_fill_way_onehot_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_en_i |-> $onehot(wr_way_i));

  assert_fill_sets_valid_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_en_i |=> ((vld_q[$past(wr_idx_i)] & $past(wr_way_i)) == $past(wr_way_i)));
endmodule

// File: rtl/vipt_data_array.sv
`timescale 1ns/1ps
module vipt_data_array #(
  parameter int SETS      = 128,
  parameter int WAYS      = 4,
  parameter int LINE_BITS = 256,
  parameter int WORD_BITS = 32,
  localparam int IDX_W  = $clog2(SETS),
  localparam int WSEL_W = $clog2(LINE_BITS / WORD_BITS)
) (
  input  logic                           clk_i,
  input  logic [IDX_W-1:0]               rd_idx_i,
  input  logic [WSEL_W-1:0]              rd_word_i,
  input  logic                           wr_en_i,
  input  logic [IDX_W-1:0]               wr_idx_i,
  input  logic [WAYS-1:0]                wr_way_i,
  input  logic [LINE_BITS-1:0]           wr_line_i,
  output logic [WAYS-1:0][WORD_BITS-1:0] rd_data_o
);
  for (genvar w = 0; w < WAYS; w++) begin : g_way
    logic [LINE_BITS-1:0] mem [SETS];
    logic [WORD_BITS-1:0] word_q;
    always_ff @(posedge clk_i) begin
      if (wr_en_i && wr_way_i[w]) mem[wr_idx_i] <= wr_line_i;
      word_q <= mem[rd_idx_i][rd_word_i*WORD_BITS +: WORD_BITS];
    end
    assign rd_data_o[w] = word_q;
  end
endmodule

// File: rtl/vipt_plru.sv
`timescale 1ns/1ps
module vipt_plru #(
  parameter int SETS = 128,
  parameter int WAYS = 4,
  localparam int IDX_W = $clog2(SETS),
  localparam int WAY_W = $clog2(WAYS),
  localparam int NODES = WAYS - 1
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [IDX_W-1:0] vic_idx_i,
  output logic [WAY_W-1:0] vic_way_o,
  input  logic             hit_en_i,
  input  logic [IDX_W-1:0] hit_idx_i,
  input  logic [WAY_W-1:0] hit_way_i,
  input  logic             fill_en_i,
  input  logic [IDX_W-1:0] fill_idx_i,
  input  logic [WAY_W-1:0] fill_way_i
);
  logic [NODES-1:0] tree_q [SETS];

  // node n (1-based heap order) lives at bit n-1; 0 steers to the lower child
  function automatic logic [WAY_W-1:0] pick(input logic [NODES-1:0] b);
    int unsigned n;
    n = 1;
    for (int l = 0; l < WAY_W; l++) n = 2 * n + (b[n-1] ? 1 : 0);
    return WAY_W'(n - WAYS);
  endfunction

  function automatic logic [NODES-1:0] touch(input logic [NODES-1:0] b,
                                             input logic [WAY_W-1:0] way);
    logic [NODES-1:0] r;
    int unsigned n;
    r = b;
    n = WAYS + 32'(way);
    for (int l = 0; l < WAY_W; l++) begin
      r[n/2-1] = (n % 2 == 0);
      n = n / 2;
    end
    return r;
  endfunction

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int s = 0; s < SETS; s++) tree_q[s] <= '0;
    end else begin
      if (hit_en_i) tree_q[hit_idx_i] <= touch(tree_q[hit_idx_i], hit_way_i);
      if (fill_en_i) tree_q[fill_idx_i] <= touch(tree_q[fill_idx_i], fill_way_i);
    end
  end

  assign vic_way_o = pick(tree_q[vic_idx_i]);

  assert_victim_moves_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fill_en_i |=> (pick(tree_q[$past(fill_idx_i)]) != $past(fill_way_i)));
endmodule

// File: rtl/vipt_l1_lookup.sv
`timescale 1ns/1ps
module vipt_l1_lookup
  import vipt_pkg::*;
#(
  parameter int SETS       = 128,
  parameter int WAYS       = 4,
  parameter int LINE_BYTES = 32,
  parameter int PPN_W      = 20,
  localparam int IDX_W     = $clog2(SETS),
  localparam int OFF_W     = $clog2(LINE_BYTES),
  localparam int POFF_W    = IDX_W + OFF_W,
  localparam int WORD_BITS = 32,
  localparam int WSEL_W    = OFF_W - 2,
  localparam int LINE_BITS = LINE_BYTES * 8,
  localparam int WAY_W     = $clog2(WAYS),
  localparam int LADDR_W   = PPN_W + IDX_W
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic                 req_valid_i,
  input  logic [POFF_W-1:0]    req_voff_i,
  input  logic                 xlat_valid_i,
  input  logic                 xlat_fault_i,
  input  logic [PPN_W-1:0]     xlat_ppn_i,
  input  logic                 fill_valid_i,
  input  logic [LADDR_W-1:0]   fill_line_i,
  input  logic [LINE_BITS-1:0] fill_data_i,
  output logic                 hit_o,
  output logic [WORD_BITS-1:0] rdata_o,
  output logic                 miss_o,
  output logic [LADDR_W-1:0]   miss_line_o,
  output logic                 err_o
);
  logic [IDX_W-1:0]  req_idx;
  logic [WSEL_W-1:0] req_word;
  logic              s1_vld_q, s1_misal_q;
  logic [IDX_W-1:0]  s1_idx_q;

  assign req_idx  = req_voff_i[POFF_W-1:OFF_W];
  assign req_word = req_voff_i[OFF_W-1:2];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      s1_vld_q   <= 1'b0;
      s1_misal_q <= 1'b0;
      s1_idx_q   <= '0;
    end else begin
      s1_vld_q   <= req_valid_i;
      s1_misal_q <= |req_voff_i[1:0];
      s1_idx_q   <= req_idx;
    end
  end

  // refill path
  logic [IDX_W-1:0] fill_idx;
  logic [PPN_W-1:0] fill_tag;
  logic [WAY_W-1:0] fill_way;
  logic [WAYS-1:0]  fill_way_oh;

  assign fill_idx    = fill_line_i[IDX_W-1:0];
  assign fill_tag    = fill_line_i[LADDR_W-1:IDX_W];
  assign fill_way_oh = WAYS'(1) << fill_way;

  logic [WAYS-1:0][PPN_W-1:0]     rd_tag;
  logic [WAYS-1:0]                rd_vld;
  logic [WAYS-1:0][WORD_BITS-1:0] rd_data;

  vipt_tag_array #(.SETS(SETS), .WAYS(WAYS), .TAG_W(PPN_W)) u_tags (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .rd_idx_i (req_idx),
    .wr_en_i  (fill_valid_i),
    .wr_idx_i (fill_idx),
    .wr_way_i (fill_way_oh),
    .wr_tag_i (fill_tag),
    .rd_tag_o (rd_tag),
    .rd_vld_o (rd_vld)
  );

  vipt_data_array #(.SETS(SETS), .WAYS(WAYS), .LINE_BITS(LINE_BITS), .WORD_BITS(WORD_BITS)) u_data (
    .clk_i     (clk_i),
    .rd_idx_i  (req_idx),
    .rd_word_i (req_word),
    .wr_en_i   (fill_valid_i),
    .wr_idx_i  (fill_idx),
    .wr_way_i  (fill_way_oh),
    .wr_line_i (fill_data_i),
    .rd_data_o (rd_data)
  );

  // late physical tag compare
  logic [WAYS-1:0]      hit_vec;
  logic [WAY_W-1:0]     hit_way;
  logic [WORD_BITS-1:0] hit_word;
  lk_res_e              res;

  always_comb begin
    hit_way  = '0;
    hit_word = '0;
    for (int w = 0; w < WAYS; w++) begin
      hit_vec[w] = rd_vld[w] && (rd_tag[w] == xlat_ppn_i);
      if (hit_vec[w]) begin
        hit_way  = hit_way | WAY_W'(w);
        hit_word = hit_word | rd_data[w];
      end
    end
  end

  always_comb begin
    if (!s1_vld_q)                         res = LK_IDLE;
    else if (s1_misal_q)                   res = LK_ERR;
    else if (!xlat_valid_i || xlat_fault_i) res = LK_CANCEL;
    else if (|hit_vec)                     res = LK_HIT;
    else                                   res = LK_MISS;
  end

  vipt_plru #(.SETS(SETS), .WAYS(WAYS)) u_plru (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .vic_idx_i  (fill_idx),
    .vic_way_o  (fill_way),
    .hit_en_i   (res == LK_HIT),
    .hit_idx_i  (s1_idx_q),
    .hit_way_i  (hit_way),
    .fill_en_i  (fill_valid_i),
    .fill_idx_i (fill_idx),
    .fill_way_i (fill_way)
  );

  assign hit_o       = (res == LK_HIT);
  assign miss_o      = (res == LK_MISS);
  assign err_o       = (res == LK_ERR);
  assign rdata_o     = hit_o ? hit_word : '0;
  assign miss_line_o = {xlat_ppn_i, s1_idx_q};

  assert_result_needs_req_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (hit_o || miss_o || err_o) |-> $past(req_valid_i));

  assert_fault_cancels_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (xlat_fault_i || !xlat_valid_i) |-> (!hit_o && !miss_o));

  assert_misalign_err_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_valid_i && (req_voff_i[1:0] != 2'b00)) |=> (err_o && !hit_o && !miss_o));

  assert_miss_index_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    miss_o |-> (miss_line_o[IDX_W-1:0] == $past(req_voff_i[POFF_W-1:OFF_W])));

  assert_hit_set_onehot_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    hit_o |-> $onehot0(hit_vec));
endmodule

// File: tb/tb_vipt_l1_lookup.sv
`timescale 1ns/1ps
module tb_vipt_l1_lookup;
  logic         clk = 1'b0;
  logic         rst_ni = 1'b0;
  logic         req_valid_i = 1'b0;
  logic [11:0]  req_voff_i = '0;
  logic         xlat_valid_i = 1'b0;
  logic         xlat_fault_i = 1'b0;
  logic [19:0]  xlat_ppn_i = '0;
  logic         fill_valid_i = 1'b0;
  logic [26:0]  fill_line_i = '0;
  logic [255:0] fill_data_i = '0;
  logic         hit_o, miss_o, err_o;
  logic [31:0]  rdata_o;
  logic [26:0]  miss_line_o;

  int checks = 0;
  int errors = 0;
  logic        r_hit, r_miss, r_err;
  logic [31:0] r_data;
  logic [26:0] r_line;

  always #2.5 clk = ~clk;

  vipt_l1_lookup dut (
    .clk_i(clk), .rst_ni(rst_ni),
    .req_valid_i(req_valid_i), .req_voff_i(req_voff_i),
    .xlat_valid_i(xlat_valid_i), .xlat_fault_i(xlat_fault_i), .xlat_ppn_i(xlat_ppn_i),
    .fill_valid_i(fill_valid_i), .fill_line_i(fill_line_i), .fill_data_i(fill_data_i),
    .hit_o(hit_o), .rdata_o(rdata_o), .miss_o(miss_o), .miss_line_o(miss_line_o), .err_o(err_o)
  );

  task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic logic [255:0] line_of(input logic [15:0] seed);
    logic [255:0] l;
    for (int k = 0; k < 8; k++) l[k*32 +: 32] = {seed, 16'(k)};
    return l;
  endfunction

  function automatic logic [11:0] voff(input logic [6:0] idx, input logic [2:0] word);
    return {idx, word, 2'b00};
  endfunction

  task automatic do_fill(input logic [19:0] ppn, input logic [6:0] idx, input logic [15:0] seed);
    @(negedge clk);
    fill_valid_i = 1'b1;
    fill_line_i  = {ppn, idx};
    fill_data_i  = line_of(seed);
    @(negedge clk);
    fill_valid_i = 1'b0;
  endtask

  task automatic lookup(input logic [11:0] off, input logic [19:0] ppn, input logic xv, input logic xf);
    @(negedge clk);
    xlat_valid_i = 1'b0;
    xlat_fault_i = 1'b0;
    req_valid_i  = 1'b1;
    req_voff_i   = off;
    @(negedge clk);
    req_valid_i  = 1'b0;
    xlat_valid_i = xv;
    xlat_fault_i = xf;
    xlat_ppn_i   = ppn;
    #1;
    r_hit  = hit_o;
    r_miss = miss_o;
    r_err  = err_o;
    r_data = rdata_o;
    r_line = miss_line_o;
  endtask

  task automatic t_reset;
    #1;
    check("R9 idle hit", 64'(hit_o), 64'd0);
    check("R9 idle miss", 64'(miss_o), 64'd0);
    check("R9 idle err", 64'(err_o), 64'd0);
    lookup(voff(7'd3, 3'd0), 20'h12345, 1'b1, 1'b0);
    check("R1 cold miss", 64'(r_miss), 64'd1);
    check("R1 cold no hit", 64'(r_hit), 64'd0);
  endtask

  task automatic t_fill_hit;
    do_fill(20'h12345, 7'd3, 16'hA1A1);
    for (int k = 0; k < 8; k++) begin
      lookup(voff(7'd3, 3'(k)), 20'h12345, 1'b1, 1'b0);
      check("R3 hit", 64'(r_hit), 64'd1);
      check("R2 R7 word select", 64'(r_data), 64'({16'hA1A1, 16'(k)}));
    end
    lookup(voff(7'd3, 3'd1), 20'h54321, 1'b1, 1'b0);
    check("R4 tag mismatch miss", 64'(r_miss), 64'd1);
    check("R4 miss line", 64'(r_line), 64'({20'h54321, 7'd3}));
    check("R4 no hit", 64'(r_hit), 64'd0);
  endtask

  task automatic t_index;
    do_fill(20'h12345, 7'd100, 16'hB2B2);
    lookup(voff(7'd100, 3'd5), 20'h12345, 1'b1, 1'b0);
    check("R2 other set hit", 64'(r_hit), 64'd1);
    check("R2 other set data", 64'(r_data), 64'({16'hB2B2, 16'd5}));
    lookup(voff(7'd3, 3'd5), 20'h12345, 1'b1, 1'b0);
    check("R2 first set data", 64'(r_data), 64'({16'hA1A1, 16'd5}));
    lookup(voff(7'd101, 3'd0), 20'h12345, 1'b1, 1'b0);
    check("R2 empty set miss", 64'(r_miss), 64'd1);
  endtask

  task automatic t_cancel;
    lookup(voff(7'd3, 3'd2), 20'h12345, 1'b0, 1'b0);
    check("R5 no xlat hit", 64'({r_hit, r_miss, r_err}), 64'd0);
    lookup(voff(7'd3, 3'd2), 20'h12345, 1'b1, 1'b1);
    check("R5 fault hit", 64'({r_hit, r_miss, r_err}), 64'd0);
    lookup(voff(7'd50, 3'd2), 20'h00777, 1'b1, 1'b1);
    check("R5 fault would-miss", 64'({r_hit, r_miss, r_err}), 64'd0);
  endtask

  task automatic t_misalign;
    lookup(voff(7'd3, 3'd2) | 12'd1, 20'h12345, 1'b1, 1'b0);
    check("R6 misaligned err", 64'({r_hit, r_miss, r_err}), 64'b001);
    lookup(voff(7'd3, 3'd2) | 12'd2, 20'h12345, 1'b1, 1'b1);
    check("R6 misaligned with fault", 64'({r_hit, r_miss, r_err}), 64'b001);
    lookup(voff(7'd9, 3'd0) | 12'd3, 20'h00001, 1'b0, 1'b0);
    check("R6 misaligned no xlat", 64'({r_hit, r_miss, r_err}), 64'b001);
  endtask

  task automatic t_idle;
    @(negedge clk);
    xlat_valid_i = 1'b1;
    xlat_fault_i = 1'b0;
    xlat_ppn_i   = 20'h12345;
    @(negedge clk);
    #1;
    check("R9 no request no result", 64'({hit_o, miss_o, err_o}), 64'd0);
    xlat_valid_i = 1'b0;
  endtask

  task automatic t_plru;
    // fills go to ways 0,2,1,3; hit on way 0 makes way 2 the victim
    do_fill(20'h00100, 7'd9, 16'h5000);
    do_fill(20'h00101, 7'd9, 16'h5001);
    do_fill(20'h00102, 7'd9, 16'h5002);
    do_fill(20'h00103, 7'd9, 16'h5003);
    for (int i = 0; i < 4; i++) begin
      lookup(voff(7'd9, 3'd4), 20'h00100 + 20'(i), 1'b1, 1'b0);
      check("R8 four ways resident", 64'(r_data), 64'({16'h5000 + 16'(i), 16'd4}));
    end
    // the last four hits touched 0,2,1,3: victim is way 0 again; hit on 0 moves it to way 2
    lookup(voff(7'd9, 3'd0), 20'h00100, 1'b1, 1'b0);
    check("R8 touch way0 hit", 64'(r_hit), 64'd1);
    do_fill(20'h00104, 7'd9, 16'h5004);
    lookup(voff(7'd9, 3'd1), 20'h00101, 1'b1, 1'b0);
    check("R8 way2 line evicted", 64'(r_miss), 64'd1);
    lookup(voff(7'd9, 3'd1), 20'h00100, 1'b1, 1'b0);
    check("R8 way0 line kept", 64'(r_data), 64'({16'h5000, 16'd1}));
    lookup(voff(7'd9, 3'd1), 20'h00102, 1'b1, 1'b0);
    check("R8 way1 line kept", 64'(r_hit), 64'd1);
    lookup(voff(7'd9, 3'd1), 20'h00103, 1'b1, 1'b0);
    check("R8 way3 line kept", 64'(r_hit), 64'd1);
    lookup(voff(7'd9, 3'd7), 20'h00104, 1'b1, 1'b0);
    check("R7 R8 new line data", 64'(r_data), 64'({16'h5004, 16'd7}));
  endtask

  initial begin
    #(5.0 * 100000);
    errors++;
    $display("FAIL watchdog expired");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_ni = 1'b1;
    t_reset();
    t_fill_hit();
    t_index();
    t_cancel();
    t_misalign();
    t_idle();
    t_plru();
    repeat (2) @(negedge clk);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule